// File: doc/BRIEF.md
# SDRAM Read Burst Truncation Sequencer

The block takes one read request at a time (bank, starting column, word count and an auto-precharge wish) and turns it into a command stream for an SDRAM whose row is already open. It sends a READ and then, when the burst would run past the wanted words, sends a stop command. The stop is either a burst-terminate or a single-bank precharge. It is timed so that the part stops driving the bus right after the last wanted word. The returned words are registered with a per-word valid strobe, and a done pulse follows the last one.

CAS latency (1, 2 or 3) and burst mode (full page or fixed length of 1, 2, 4 or 8 words) come from static configuration inputs. They are sampled when a request is accepted. A fixed-length read issued with auto-precharge cannot be cut short. In that case the burst runs to its natural end, the requested words are still the only ones delivered, and the request is flagged as not truncatable. The stop cycle is counted from the READ: the stop for an N-word request lands N cycles after the READ. That is CL-1 cycles ahead of the edge that carries the last wanted word, and at CL=1 it falls on that same edge.

Top module: `sdram_rd_trunc`

## Requirements
- R1: A request is taken on a rising edge where req_valid_i and ready_o are both high, and the next cycle shows READ on cmd_o. Command codes are 0 NOP, 1 READ, 2 burst-terminate, 3 precharge. With the READ, cmd_bank_o carries the bank, cmd_addr_o[7:0] carries the column, and cmd_addr_o[10] is the auto-precharge bit. That bit is 1 only for a fixed-length request with req_auto_pre_i high, and the other address bits are 0.
- R2: Count the READ cycle as 0. For a truncated request of effective length N, the stop command appears in cycle N. That is CL-1 cycles before the edge ending cycle CL+N-1, which captures the last wanted word. N=1 therefore puts the stop in the cycle right after the READ.
- R3: The stop command is code 2 when cfg_stop_pre_i is low and code 3 when it is high. Either way it carries the request's bank and an all-zero address.
- R4: In full-page mode (cfg_full_page_i high) every request is truncated. A length of 0 counts as 1, and lengths above 256 are clamped to 256.
- R5: In fixed mode the burst length is 2^cfg_burst_len_i. A longer request is clamped to that length, and a request equal to it gets no stop command.
- R6: A fixed-length request with req_auto_pre_i high and a length below the burst length gets no stop command. It raises no_trunc_o together with done_o, and it keeps ready_o low until the burst's natural end.
- R7: Word k of an N-word request (k < N) is the value on dq_i at the edge ending cycle CL+k. It appears on data_o with data_valid_o high in cycle CL+k+1. data_valid_o is high in no other cycle.
- R8: done_o is high for exactly one cycle, the cycle CL+N+1, right after the last valid word.
- R9: ready_o is low from the READ cycle through cycle CL+W, where W is the number of words the part drives (N when truncated, otherwise the burst length). A request raised while ready_o is low is ignored.
- R10: dqm_o is low in every busy cycle and high while idle. cmd_o is NOP in every cycle other than the READ and the stop.
- R11: cfg_cas_lat_i gives CAS latency 1, 2 or 3 directly, and the code 0 is taken as latency 1.
- R12: While rst_ni is low, ready_o=1, cmd_o=NOP, dqm_o=1, data_valid_o=0 and done_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_cas_lat_i | input | 2 | CAS latency code (0 treated as 1) |
| cfg_full_page_i | input | 1 | 1: full-page bursts, 0: fixed length |
| cfg_burst_len_i | input | 2 | Fixed burst length exponent (1,2,4,8 words) |
| cfg_stop_pre_i | input | 1 | 1: stop with precharge, 0: burst-terminate |
| req_valid_i | input | 1 | Request strobe |
| req_bank_i | input | 2 | Bank of the request |
| req_col_i | input | 8 | Starting column |
| req_len_i | input | 9 | Wanted word count |
| req_auto_pre_i | input | 1 | Auto-precharge wish |
| ready_o | output | 1 | Idle, able to accept a request |
| cmd_o | output | 2 | SDRAM command code |
| cmd_bank_o | output | 2 | Command bank |
| cmd_addr_o | output | 11 | Command address |
| dqm_o | output | 1 | Data mask, low while reading |
| dq_i | input | 16 | SDRAM read data |
| data_o | output | 16 | Captured word |
| data_valid_o | output | 1 | data_o holds a wanted word |
| done_o | output | 1 | Request complete pulse |
| no_trunc_o | output | 1 | Request could not be truncated (with done_o) |

## Verification
At CAS latency 1 the stop command and the capture of the last wanted word fall on the same edge. A one-word request pushes this further, so that the stop follows the READ immediately. The bench drives a memory model that stops returning real words as soon as it sees the stop. Any stop that is one cycle early therefore shows up as a garbage word on data_o, and any stop that is late shows up as a cmd_o mismatch. A second overlap is done_o coinciding with ready_o rising. The bench issues a new request in that very cycle and expects its READ in the following cycle, with no stale valid or done from the previous request.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;
  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_READ  = 2'd1,
    CMD_BTERM = 2'd2,
    CMD_PRE   = 2'd3
  } cmd_e;
endpackage

// File: rtl/sdram_rd_req_decode.sv
module sdram_rd_req_decode #(
  parameter int LEN_W      = 9,
  parameter int CNT_W      = 9,
  parameter int CL_W       = 2,
  parameter int BL_W       = 2,
  parameter int PAGE_WORDS = 256
) (
  input  logic [LEN_W-1:0] len_i,
  input  logic             auto_pre_i,
  input  logic [CL_W-1:0]  cl_code_i,
  input  logic             full_page_i,
  input  logic [BL_W-1:0]  bl_code_i,
  output logic [CL_W-1:0]  cl_o,
  output logic [CNT_W-1:0] n_eff_o,
  output logic [CNT_W-1:0] end_cnt_o,
  output logic             trunc_o,
  output logic             no_trunc_o,
  output logic             ap_bit_o
);
  logic [CNT_W-1:0] len_n, limit, words;

  always_comb begin
    cl_o    = (cl_code_i == '0) ? CL_W'(1) : cl_code_i;
    len_n   = (len_i == '0) ? CNT_W'(1) : CNT_W'(len_i);
    limit   = full_page_i ? CNT_W'(PAGE_WORDS) : (CNT_W'(1) << bl_code_i);
    n_eff_o = (len_n > limit) ? limit : len_n;
    // auto-precharge only meaningful for fixed-length bursts
    ap_bit_o   = auto_pre_i & ~full_page_i;
    trunc_o    = full_page_i | (~auto_pre_i & (n_eff_o < limit));
    no_trunc_o = ap_bit_o & (len_n < limit);
    words      = trunc_o ? n_eff_o : limit;
    end_cnt_o  = CNT_W'(cl_o) + words;
  end
endmodule

// File: rtl/sdram_rd_cmd_seq.sv
module sdram_rd_cmd_seq
  import sdram_rd_pkg::*;
#(
  parameter int CNT_W  = 9,
  parameter int CL_W   = 2,
  parameter int BANK_W = 2,
  parameter int COL_W  = 8,
  parameter int ADDR_W = 11,
  parameter int AP_BIT = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic              stop_pre_i,
  input  logic [CL_W-1:0]   cl_i,
  input  logic [CNT_W-1:0]  n_eff_i,
  input  logic [CNT_W-1:0]  end_cnt_i,
  input  logic              trunc_i,
  input  logic              no_trunc_i,
  input  logic              ap_bit_i,
  output logic              ready_o,
  output cmd_e              cmd_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              dqm_o,
  output logic              slot_o,
  output logic              slot_last_o,
  output logic              no_trunc_o,
  output logic [CL_W-1:0]   cl_o
);
  logic              busy_q, trunc_q, nt_q;
  logic [CNT_W-1:0]  cnt_q, n_q, end_q;
  cmd_e              cmd_q, stop_q;
  logic [BANK_W-1:0] bank_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CL_W-1:0]   cl_q;
  logic [ADDR_W-1:0] read_addr;

  always_comb begin
    read_addr = ADDR_W'(req_col_i);
    if (ap_bit_i) read_addr[AP_BIT] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      trunc_q <= 1'b0;
      nt_q    <= 1'b0;
      cnt_q   <= '0;
      n_q     <= '0;
      end_q   <= '0;
      cmd_q   <= CMD_NOP;
      stop_q  <= CMD_BTERM;
      bank_q  <= '0;
      addr_q  <= '0;
      cl_q    <= CL_W'(1);
    end else if (!busy_q) begin
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      if (req_valid_i) begin
        busy_q  <= 1'b1;
        cnt_q   <= '0;
        n_q     <= n_eff_i;
        end_q   <= end_cnt_i;
        trunc_q <= trunc_i;
        nt_q    <= no_trunc_i;
        stop_q  <= stop_pre_i ? CMD_PRE : CMD_BTERM;
        bank_q  <= req_bank_i;
        cl_q    <= cl_i;
        cmd_q   <= CMD_READ;
        addr_q  <= read_addr;
      end
    end else if (cnt_q == end_q) begin
      busy_q <= 1'b0;
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
      addr_q <= '0;
      // stop lands N cycles after READ = CL-1 before the last wanted edge
      cmd_q  <= (trunc_q && (cnt_q + CNT_W'(1) == n_q)) ? stop_q : CMD_NOP;
    end
  end

  assign ready_o     = ~busy_q;
  assign dqm_o       = ~busy_q;
  assign cmd_o       = cmd_q;
  assign bank_o      = bank_q;
  assign addr_o      = addr_q;
  assign slot_o      = busy_q & (cnt_q < n_q);
  assign slot_last_o = busy_q & (cnt_q == n_q - CNT_W'(1));
  assign no_trunc_o  = nt_q;
  assign cl_o        = cl_q;
endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture #(
  parameter int DATA_W = 16,
  parameter int CL_W   = 2,
  parameter int MAX_CL = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slot_i,
  input  logic              slot_last_i,
  input  logic              no_trunc_i,
  input  logic [CL_W-1:0]   cl_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              done_o,
  output logic              no_trunc_o
);
  logic [MAX_CL:1]   tok_q, lst_q;
  logic              tap_tok, tap_lst;
  logic              valid_q, last_q, done_q;
  logic [DATA_W-1:0] data_q;

  // slot tokens delayed by the CAS latency mark cycles holding wanted words
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tok_q <= '0;
      lst_q <= '0;
    end else begin
      for (int j = 1; j <= MAX_CL; j++) begin
        tok_q[j] <= (j == 1) ? slot_i      : tok_q[j-1];
        lst_q[j] <= (j == 1) ? slot_last_i : lst_q[j-1];
      end
    end
  end

  always_comb begin
    tap_tok = 1'b0;
    tap_lst = 1'b0;
    for (int j = 1; j <= MAX_CL; j++) begin
      if (int'(cl_i) == j) begin
        tap_tok = tok_q[j];
        tap_lst = lst_q[j];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      valid_q <= tap_tok;
      last_q  <= tap_tok & tap_lst;
      done_q  <= valid_q & last_q;
      if (tap_tok) data_q <= dq_i;
    end
  end

  assign data_o     = data_q;
  assign valid_o    = valid_q;
  assign done_o     = done_q;
  assign no_trunc_o = done_q & no_trunc_i;
endmodule

// File: rtl/sdram_rd_trunc.sv
module sdram_rd_trunc
  import sdram_rd_pkg::*;
#(
  parameter int BANK_W     = 2,
  parameter int COL_W      = 8,
  parameter int ADDR_W     = 11,
  parameter int AP_BIT     = 10,
  parameter int LEN_W      = 9,
  parameter int DATA_W     = 16,
  parameter int PAGE_WORDS = 256,
  parameter int MAX_CL     = 3,
  parameter int BL_W       = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cfg_cas_lat_i,
  input  logic              cfg_full_page_i,
  input  logic [BL_W-1:0]   cfg_burst_len_i,
  input  logic              cfg_stop_pre_i,
  input  logic              req_valid_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              req_auto_pre_i,
  output logic              ready_o,
  output logic [1:0]        cmd_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic              dqm_o,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_valid_o,
  output logic              done_o,
  output logic              no_trunc_o
);
  localparam int CL_W   = 2;
  localparam int SPAN   = PAGE_WORDS + MAX_CL + 2;
  localparam int CNT_W  = ($clog2(SPAN) > LEN_W) ? $clog2(SPAN) : LEN_W;

  logic [CL_W-1:0]  dec_cl, act_cl;
  logic [CNT_W-1:0] dec_n, dec_end;
  logic             dec_trunc, dec_nt, dec_ap;
  logic             slot, slot_last, nt_held;
  cmd_e             cmd;

  sdram_rd_req_decode #(
    .LEN_W(LEN_W), .CNT_W(CNT_W), .CL_W(CL_W), .BL_W(BL_W), .PAGE_WORDS(PAGE_WORDS)
  ) u_dec (
    .len_i      (req_len_i),
    .auto_pre_i (req_auto_pre_i),
    .cl_code_i  (cfg_cas_lat_i),
    .full_page_i(cfg_full_page_i),
    .bl_code_i  (cfg_burst_len_i),
    .cl_o       (dec_cl),
    .n_eff_o    (dec_n),
    .end_cnt_o  (dec_end),
    .trunc_o    (dec_trunc),
    .no_trunc_o (dec_nt),
    .ap_bit_o   (dec_ap)
  );

  sdram_rd_cmd_seq #(
    .CNT_W(CNT_W), .CL_W(CL_W), .BANK_W(BANK_W), .COL_W(COL_W),
    .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_bank_i  (req_bank_i),
    .req_col_i   (req_col_i),
    .stop_pre_i  (cfg_stop_pre_i),
    .cl_i        (dec_cl),
    .n_eff_i     (dec_n),
    .end_cnt_i   (dec_end),
    .trunc_i     (dec_trunc),
    .no_trunc_i  (dec_nt),
    .ap_bit_i    (dec_ap),
    .ready_o     (ready_o),
    .cmd_o       (cmd),
    .bank_o      (cmd_bank_o),
    .addr_o      (cmd_addr_o),
    .dqm_o       (dqm_o),
    .slot_o      (slot),
    .slot_last_o (slot_last),
    .no_trunc_o  (nt_held),
    .cl_o        (act_cl)
  );

  sdram_rd_capture #(
    .DATA_W(DATA_W), .CL_W(CL_W), .MAX_CL(MAX_CL)
  ) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .slot_i     (slot),
    .slot_last_i(slot_last),
    .no_trunc_i (nt_held),
    .cl_i       (act_cl),
    .dq_i       (dq_i),
    .data_o     (data_o),
    .valid_o    (data_valid_o),
    .done_o     (done_o),
    .no_trunc_o (no_trunc_o)
  );

  assign cmd_o = cmd;
endmodule

// File: rtl/sdram_rd_trunc_chk.sv
module sdram_rd_trunc_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_full_page_i,
  input logic       req_valid_i,
  input logic       ready_o,
  input logic [1:0] cmd_o,
  input logic       dqm_o,
  input logic       data_valid_o,
  input logic       done_o,
  input logic       no_trunc_o
);
  // R1
  a_r1_accept_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ready_o) |=> (cmd_o == 2'd1));
  // R9
  a_r9_read_only_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 2'd1) |-> $past(req_valid_i && ready_o));
  // R10
  a_r10_idle_nop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (cmd_o == 2'd0));
  // R10
  a_r10_dqm_low_on_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> $past(!dqm_o));
  // R3
  a_r3_stop_then_nop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o[1]) |=> (cmd_o == 2'd0));
  // R8
  a_r8_done_after_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(data_valid_o));
  // R8
  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R6
  a_r6_flag_fixed_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_trunc_o |-> !cfg_full_page_i);
endmodule

bind sdram_rd_trunc sdram_rd_trunc_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cfg_full_page_i(cfg_full_page_i),
  .req_valid_i    (req_valid_i),
  .ready_o        (ready_o),
  .cmd_o          (cmd_o),
  .dqm_o          (dqm_o),
  .data_valid_o   (data_valid_o),
  .done_o         (done_o),
  .no_trunc_o     (no_trunc_o)
);

// File: tb/sdram_rd_trunc_test.sv
module sdram_rd_trunc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_cl = 2'd1;
  logic        cfg_full = 1'b1;
  logic [1:0]  cfg_bl = 2'd0;
  logic        cfg_pre = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_bank = '0;
  logic [7:0]  req_col = '0;
  logic [8:0]  req_len = '0;
  logic        req_ap = 1'b0;
  logic        ready, dqm, dvalid, done, ntr;
  logic [1:0]  cmd, cbank;
  logic [10:0] caddr;
  logic [15:0] dq = 16'hBAD0;
  logic [15:0] dout;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  bit live = 1'b0;
  string ctx = "R12 reset";

  sdram_rd_trunc uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_cas_lat_i(cfg_cl), .cfg_full_page_i(cfg_full),
    .cfg_burst_len_i(cfg_bl), .cfg_stop_pre_i(cfg_pre),
    .req_valid_i(req_valid), .req_bank_i(req_bank), .req_col_i(req_col),
    .req_len_i(req_len), .req_auto_pre_i(req_ap),
    .ready_o(ready), .cmd_o(cmd), .cmd_bank_o(cbank), .cmd_addr_o(caddr),
    .dqm_o(dqm), .dq_i(dq), .data_o(dout), .data_valid_o(dvalid),
    .done_o(done), .no_trunc_o(ntr)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // expected outputs keyed by cycle number
  int         exp_cmd[int];
  int         exp_addr[int];
  int         exp_bank[int];
  int         exp_data[int];
  bit         exp_done[int];
  bit         exp_nt[int];
  int         busy_from = -10;
  int         busy_to = -10;

  // memory model state
  int m_r = -1000, m_cl = 1, m_lim = 1, m_stop = 1 << 30;
  int m_bank = 0, m_col = 0;

  function automatic int pat(int b, int c, int k);
    return 16'h4000 + b * 1024 + ((c + k) & 1023);
  endfunction

  function automatic int norm_cl(logic [1:0] code);
    return (code == 2'd0) ? 1 : int'(code);
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s] cycle %0d actual=%0h expected=%0h", req, ctx, cyc, act, expv);
    end
  endtask

  task automatic schedule(int a, int bank, int col, int len, bit ap);
    int r, cl, ln, lim, n, w;
    bit trunc, nt;
    r     = a + 1;
    cl    = norm_cl(cfg_cl);
    ln    = (len == 0) ? 1 : len;
    lim   = cfg_full ? 256 : (1 << cfg_bl);
    n     = (ln > lim) ? lim : ln;
    trunc = cfg_full || (!ap && n < lim);
    w     = trunc ? n : lim;
    nt    = !cfg_full && ap && ln < lim;
    exp_cmd[r]  = 1;
    exp_addr[r] = col + ((ap && !cfg_full) ? 1024 : 0);
    exp_bank[r] = bank;
    if (trunc) begin
      exp_cmd[r+n]  = cfg_pre ? 3 : 2;
      exp_addr[r+n] = 0;
      exp_bank[r+n] = bank;
    end
    for (int k = 0; k < n; k++) exp_data[r+cl+k+1] = pat(bank, col, k);
    exp_done[r+cl+n+1] = 1'b1;
    exp_nt[r+cl+n+1]   = nt;
    busy_from = r;
    busy_to   = r + cl + w;
  endtask

  // memory model and per-cycle comparison
  always @(negedge clk) begin
    int k, ec;
    bit er;
    if (live) begin
      if (cmd == 2'd1) begin
        m_r = cyc; m_bank = int'(cbank); m_col = int'(caddr[7:0]);
        m_cl = norm_cl(cfg_cl); m_lim = cfg_full ? 256 : (1 << cfg_bl);
        m_stop = 1 << 30;
      end else if (cmd[1] && cyc > m_r) begin
        m_stop = cyc;
      end
      k = cyc - m_r - m_cl;
      dq = (k >= 0 && k < m_lim && k < m_stop - m_r) ? 16'(pat(m_bank, m_col, k)) : 16'hBAD0;

      ec = exp_cmd.exists(cyc) ? exp_cmd[cyc] : 0;
      check(int'(cmd) == ec, (ec == 1) ? "R1" : (ec == 0) ? "R10" : "R3", int'(cmd), ec);
      if (ec != 0) begin
        check(int'(caddr) == exp_addr[cyc], "R1", int'(caddr), exp_addr[cyc]);
        check(int'(cbank) == exp_bank[cyc], "R3", int'(cbank), exp_bank[cyc]);
      end
      check(dvalid == exp_data.exists(cyc), "R7", int'(dvalid), int'(exp_data.exists(cyc)));
      if (exp_data.exists(cyc))
        check(int'(dout) == exp_data[cyc], "R7", int'(dout), exp_data[cyc]);
      check(done == exp_done.exists(cyc), "R8", int'(done), int'(exp_done.exists(cyc)));
      check(ntr == (exp_nt.exists(cyc) && exp_nt[cyc]), "R6", int'(ntr),
            int'(exp_nt.exists(cyc) && exp_nt[cyc]));
      er = !(cyc >= busy_from && cyc <= busy_to);
      check(ready == er, "R9", int'(ready), int'(er));
      check(dqm == er, "R10", int'(dqm), int'(er));
    end
  end

  task automatic rd(string c, logic [1:0] cl, bit full, logic [1:0] bl, bit pre,
                    int bank, int col, int len, bit ap);
    @(negedge clk);
    while (!ready) @(negedge clk);
    ctx = c;
    cfg_cl = cl; cfg_full = full; cfg_bl = bl; cfg_pre = pre;
    req_bank = 2'(bank); req_col = 8'(col); req_len = 9'(len); req_ap = ap;
    req_valid = 1'b1;
    schedule(cyc, bank, col, len, ap);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog [%s] actual=running expected=finished", ctx);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R12: reset values
    check(ready == 1'b1, "R12", int'(ready), 1);
    check(cmd == 2'd0, "R12", int'(cmd), 0);
    check(dqm == 1'b1, "R12", int'(dqm), 1);
    check(dvalid == 1'b0, "R12", int'(dvalid), 0);
    check(done == 1'b0, "R12", int'(done), 0);
    rst_n = 1'b1;
    idle(2);
    live = 1'b1;

    for (int cl = 1; cl <= 3; cl++) begin
      rd("R2 full page len 4", 2'(cl), 1, 0, 0, 1, 16, 4, 0);
      idle(3);
      rd("R2 single word", 2'(cl), 1, 0, 0, 2, 40, 1, 0);
      idle(3);
      rd("R5 fixed 4 len 3", 2'(cl), 0, 2, 0, 3, 8, 3, 0);
      idle(3);
      rd("R5 fixed 4 len 4 no stop", 2'(cl), 0, 2, 0, 0, 12, 4, 0);
      idle(3);
      rd("R5 fixed 4 len 6 clamp", 2'(cl), 0, 2, 0, 1, 20, 6, 0);
      idle(3);
      rd("R6 fixed 8 auto-pre len 2", 2'(cl), 0, 3, 0, 2, 64, 2, 1);
      idle(3);
      rd("R3 precharge stop", 2'(cl), 1, 0, 1, 3, 100, 3, 0);
      idle(3);
    end
    rd("R4 zero length", 2'd2, 1, 0, 0, 1, 5, 0, 0);
    idle(2);
    rd("R11 latency code 0", 2'd0, 1, 0, 0, 0, 77, 2, 0);
    idle(2);
    rd("R6 auto-pre full length", 2'd2, 0, 1, 0, 1, 3, 2, 1);
    idle(2);
    rd("R1 auto-pre ignored in full page", 2'd1, 1, 0, 0, 2, 9, 3, 1);
    idle(2);
    rd("R4 clamp to page", 2'd3, 1, 0, 0, 3, 200, 300, 0);
    idle(2);

    // R9: request while busy is ignored
    rd("R9 busy request", 2'd3, 1, 0, 0, 1, 30, 5, 0);
    ctx = "R9 ignored request";
    req_bank = 2'd2; req_col = 8'd99; req_len = 9'd2;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    idle(12);

    // R8/R9: back-to-back, new accept in the done cycle
    rd("R8 back-to-back a", 2'd1, 1, 0, 0, 0, 50, 1, 0);
    rd("R8 back-to-back b", 2'd1, 1, 0, 0, 1, 60, 2, 0);
    rd("R8 back-to-back c", 2'd3, 0, 2, 1, 2, 70, 4, 0);
    idle(15);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule